// File: doc/BRIEF.md
# Keyed Watchdog Timer with Pulse Output

This block is a watchdog timer that runs entirely on one oscillator clock. The clock is first reduced by a fixed base divider and then by a power-of-two prescaler chosen in a control register. The resulting single-cycle tick advances an up counter. When the counter reaches its all-ones value, the block emits an active-low pulse of fixed length. The pulse goes to the reset output, or to the interrupt output when the interrupt-enable input is high.

Software keeps the watchdog quiet by writing a two-step key to the key register: first 0x55, then 0xAA. It can also stop the watchdog with a disable bit. Every control-register write must carry a fixed check pattern. A write with any other pattern is treated as a fault and starts a reset pulse at once.

Top module: `wdg_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), both `wdg_rst_n` and `wdg_int_n` are high, the counter is zero, the key detector is disarmed, the disable bit is clear and the prescale field is 0.
- R2: A count tick occurs once every `PRE_DIV * D` clock cycles. D is 1 for prescale field values 0 and 1, and 2^(n-1) for a value n of 2 to 7. The prescale field is `wr_data[2:0]` of a control write.
- R3: The counter (`CNT_W` bits) increments on each tick. In the cycle after it holds all ones, it returns to zero and an expiry pulse starts.
- R4: A key write (`wr_sel`=1) of 0x55 arms the key detector, and a repeated 0x55 leaves it armed. A write of 0xAA while armed clears the counter and disarms the detector. Any other key write disarms it without clearing the counter.
- R5: A control write (`wr_sel`=0) whose check field `wr_data[6:4]` is not 3'b101 leaves the control register unchanged. It starts a reset pulse on the next edge, whatever `irq_en` is.
- R6: When the disable bit `wr_data[7]`, taken from a control write with a good check field, is set, the counter is held at zero and no expiry occurs.
- R7: At expiry, `irq_en`=0 routes the pulse to `wdg_rst_n`, and `irq_en`=1 routes it to `wdg_int_n`. The two outputs are never low together.
- R8: Every pulse holds its output low for exactly `PULSE_LEN` clock cycles. Events that occur while a pulse is active start no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control register, 1 key register |
| wr_data | input | 8 | Write data |
| irq_en | input | 1 | Routes expiry to the interrupt output instead of reset |
| wdg_rst_n | output | 1 | Active-low watchdog reset pulse |
| wdg_int_n | output | 1 | Active-low watchdog interrupt pulse |

## Verification
The assertions check the following on every cycle:
- the two outputs are never low together;
- the counter wraps to zero right after holding all ones;
- a disabled watchdog keeps the counter at zero;
- an armed 0xAA key write clears the counter;
- a bad check pattern on an idle block pulls the reset low on the next edge;
- a falling output stays low for at least one more cycle.

Other behaviour needs the bench's scenarios and its cycle-accurate reference model. This covers the exact tick spacing for each prescale value, the full pulse width, the broken key orders (0x55, other value, 0xAA), the unchanged control register after a bad write, and the choice of output under `irq_en`.

// File: rtl/wdg_pkg.sv
// Package: shared constants and the control register layout for the watchdog.
// Assumes 8-bit register writes.
package wdg_pkg;

    localparam logic [7:0] KEY_ARM   = 8'h55;
    localparam logic [7:0] KEY_CLEAR = 8'hAA;
    localparam logic [2:0] CHK_GOOD  = 3'b101;

    // Control register: [7] disable, [6:4] check, [3] spare, [2:0] prescale
    typedef struct packed {
        logic       dis;
        logic [2:0] chk;
        logic       spare;
        logic [2:0] ps;
    } wdg_ctrl_t;

endpackage

// File: rtl/wdg_prescale.sv
// Module: two-stage tick generator. A fixed divide-by-PRE_DIV stage feeds a
// programmable power-of-two stage. Assumes PRE_DIV >= 2.
// The output is a one-cycle enable.
module wdg_prescale #(
    parameter int PRE_DIV = 512,
    parameter int PS_W    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int PRE_W = $clog2(PRE_DIV);
    localparam int SUB_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] lim;
    logic             base_tick;

    // Limit of the programmable stage: 0 for ps 0 and 1, else 2^(ps-1)-1.
    always_comb begin
        if (ps < PS_W'(2))
            lim = '0;
        else
            lim = (SUB_W'(1) << (ps - PS_W'(1))) - SUB_W'(1);
    end

    assign base_tick = (pre_q == PRE_W'(PRE_DIV - 1));
    assign tick      = base_tick && (sub_q >= lim);

    // Fixed base divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (base_tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    // Programmable stage: counts base ticks up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub_q <= '0;
        else if (base_tick) begin
            if (sub_q >= lim)
                sub_q <= '0;
            else
                sub_q <= sub_q + SUB_W'(1);
        end
    end
endmodule

// File: rtl/wdg_key_detect.sv
// Module: two-step service key detector. 0x55 arms it. 0xAA while armed
// gives a one-cycle clear. Any other key write disarms it.
// Assumes key_wr lasts one cycle per write.
module wdg_key_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       svc_clear,
    output logic       armed
);
    import wdg_pkg::*;

    assign svc_clear = key_wr && armed && (key_data == KEY_CLEAR);

    // Arm state: set by 0x55, cleared by any other key value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (key_wr)
            armed <= (key_data == KEY_ARM);
    end
endmodule

// File: rtl/wdg_pulse.sv
// Module: fixed-width active-low pulse generator with output routing.
// Starts only while idle, so it cannot retrigger. A forced reset overrides
// interrupt routing.
module wdg_pulse #(
    parameter int PULSE_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic force_rst,
    input  logic irq_en,
    output logic rst_o_n,
    output logic int_o_n
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;
    logic          to_int_q;
    logic          active;
    logic          start;

    assign active = (left_q != '0);
    assign start  = (expire || force_rst) && !active;

    // Remaining low cycles of the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (active)
            left_q <= left_q - PW'(1);
        else if (start)
            left_q <= PW'(PULSE_LEN);
    end

    // Output routing, captured at pulse start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            to_int_q <= 1'b0;
        else if (start)
            to_int_q <= irq_en && !force_rst;
    end

    assign rst_o_n = !(active && !to_int_q);
    assign int_o_n = !(active && to_int_q);
endmodule

// File: rtl/wdg_timer.sv
// Module: top of the keyed watchdog timer. Holds the control register and
// the up counter, and connects the prescaler, key detector and pulse
// generator. Everything runs on one clock with a synchronous active-low reset.
module wdg_timer #(
    parameter int PRE_DIV   = 512,
    parameter int PS_W      = 3,
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       irq_en,
    output logic       wdg_rst_n,
    output logic       wdg_int_n
);
    import wdg_pkg::*;

    wdg_ctrl_t        ctrl_q;
    wdg_ctrl_t        wr_ctrl;
    logic             dis_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             svc_clear;
    logic             key_armed;
    logic             ctrl_wr;
    logic             bad_chk;
    logic             expire;

    assign wr_ctrl = wdg_ctrl_t'(wr_data);
    assign ctrl_wr = wr_en && !wr_sel;
    assign bad_chk = ctrl_wr && (wr_ctrl.chk != CHK_GOOD);
    assign dis_q   = ctrl_q.dis;
    assign expire  = (cnt_q == '1);

    // Control register: updated only by writes with a good check field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr && !bad_chk)
            ctrl_q <= wr_ctrl;
    end

    // Watchdog up counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (dis_q || expire || svc_clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    wdg_prescale #(.PRE_DIV(PRE_DIV), .PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .ps    (ctrl_q.ps[PS_W-1:0]),
        .tick  (tick)
    );

    wdg_key_detect u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (wr_en && wr_sel),
        .key_data  (wr_data),
        .svc_clear (svc_clear),
        .armed     (key_armed)
    );

    wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .force_rst (bad_chk),
        .irq_en    (irq_en),
        .rst_o_n   (wdg_rst_n),
        .int_o_n   (wdg_int_n)
    );
endmodule

// File: rtl/wdg_timer_chk.sv
// Module: assertion checker for wdg_timer, attached with bind. It reads the
// counter, the disable bit and the arm state from the top module's scope.
module wdg_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [7:0]       wr_data,
    input logic             wdg_rst_n,
    input logic             wdg_int_n,
    input logic [CNT_W-1:0] cnt_q,
    input logic             dis_q,
    input logic             key_armed
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wdg_rst_n && wdg_int_n));

    assert_wrap_on_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '0));

    assert_service_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && key_armed && wr_data == 8'hAA) |=> (cnt_q == '0));

    assert_bad_check_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[6:4] != 3'b101 && wdg_rst_n && wdg_int_n)
        |=> !wdg_rst_n);

    assert_disable_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |=> (cnt_q == '0));

    assert_exclusive_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_rst_n || wdg_int_n));

    assert_pulse_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdg_rst_n) |=> !wdg_rst_n);
endmodule

bind wdg_timer wdg_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .wdg_rst_n (wdg_rst_n),
    .wdg_int_n (wdg_int_n),
    .cnt_q     (cnt_q),
    .dis_q     (dis_q),
    .key_armed (key_armed)
);

// File: tb/wdg_timer_test.sv
// Bench for wdg_timer. A behavioural reference model is compared with the
// outputs on every cycle, and directed scenarios add their own checks.
module wdg_timer_test;
    localparam int PRE = 4;
    localparam int LEN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_en = 1'b0;
    logic       wdg_rst_n;
    logic       wdg_int_n;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wdg_timer #(.PRE_DIV(PRE), .PS_W(3), .CNT_W(8), .PULSE_LEN(LEN)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq_en(irq_en),
        .wdg_rst_n(wdg_rst_n), .wdg_int_n(wdg_int_n)
    );

    // Reference model state, in plain integers.
    int  m_pre = 0, m_sub = 0, m_cnt = 0, m_left = 0, m_ps = 0;
    bit  m_dis = 0, m_armed = 0, m_to_int = 0;

    always @(posedge clk) begin
        int  lim;
        bit  tk, fire, clr, badw;
        if (!rst_n) begin
            m_pre = 0; m_sub = 0; m_cnt = 0; m_left = 0; m_ps = 0;
            m_dis = 0; m_armed = 0; m_to_int = 0;
        end else begin
            lim  = (m_ps < 2) ? 0 : (1 << (m_ps - 1)) - 1;
            tk   = (m_pre == PRE - 1) && (m_sub >= lim);
            fire = (m_cnt == 255);
            clr  = wr_en && wr_sel && m_armed && (wr_data == 8'hAA);
            badw = wr_en && !wr_sel && (wr_data[6:4] != 3'b101);
            if (m_pre == PRE - 1) begin
                m_pre = 0;
                m_sub = (m_sub >= lim) ? 0 : m_sub + 1;
            end else m_pre++;
            if (m_dis || fire || clr) m_cnt = 0;
            else if (tk) m_cnt++;
            if (m_left > 0) m_left--;
            else if (fire || badw) begin
                m_left = LEN;
                m_to_int = irq_en && !badw;
            end
            if (wr_en && wr_sel) m_armed = (wr_data == 8'h55);
            if (wr_en && !wr_sel && !badw) begin
                m_dis = wr_data[7];
                m_ps  = int'(wr_data[2:0]);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, cycles);
        end
    endtask

    // Compare with the model on every cycle, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(wdg_rst_n == !(m_left > 0 && !m_to_int), "R3 R7 R8 model rst_n",
                  int'(wdg_rst_n), int'(!(m_left > 0 && !m_to_int)));
            check(wdg_int_n == !(m_left > 0 && m_to_int), "R7 R8 model int_n",
                  int'(wdg_int_n), int'(!(m_left > 0 && m_to_int)));
        end
        if (cycles > 190000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait for an output to go low (up to tmo cycles), then measure its width.
    task automatic wait_low(input bit on_int, input int tmo, output int waited, output int width);
        waited = 0; width = 0;
        while (waited < tmo && (on_int ? wdg_int_n : wdg_rst_n)) begin
            @(negedge clk); waited++;
        end
        while (!(on_int ? wdg_int_n : wdg_rst_n) && width < 4 * LEN) begin
            @(negedge clk); width++;
        end
    endtask

    // Count low cycles on either output over n cycles.
    task automatic quiet(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!wdg_rst_n || !wdg_int_n) lows++;
        end
    endtask

    initial begin
        int w, wd, lows;
        do_reset();
        @(negedge clk);
        check(wdg_rst_n && wdg_int_n, "R1 outputs high after reset",
              int'({wdg_rst_n, wdg_int_n}), 3);

        // Free-running expiry, /1 prescale, reset route: 255 ticks of PRE cycles.
        wait_low(1'b0, 3000, w, wd);
        check(w > 255 * PRE - 8 && w < 256 * PRE + 8, "R2 R3 expiry time /1",
              w, 255 * PRE);
        check(wd == LEN, "R8 reset pulse width", wd, LEN);
        check(wdg_int_n, "R7 int stays high on reset route", int'(wdg_int_n), 1);

        // Regular service keeps it quiet.
        for (int k = 0; k < 10; k++) begin
            repeat (150) @(negedge clk);
            wr(1'b1, 8'h55); wr(1'b1, 8'hAA);
        end
        quiet(100, lows);
        check(lows == 0, "R4 serviced watchdog stays quiet", lows, 0);

        // Repeated 0x55 keeps it armed.
        for (int k = 0; k < 8; k++) begin
            repeat (150) @(negedge clk);
            wr(1'b1, 8'h55); wr(1'b1, 8'h55); wr(1'b1, 8'hAA);
        end
        quiet(50, lows);
        check(lows == 0, "R4 repeated 0x55 still arms", lows, 0);

        // Broken order (0x55, other, 0xAA) does not service.
        repeat (100) @(negedge clk);
        wr(1'b1, 8'h55); wr(1'b1, 8'h12); wr(1'b1, 8'hAA);
        wait_low(1'b0, 1200, w, wd);
        check(w < 1200, "R4 broken key order does not clear", w, 1020);

        // Bad check field: reset on next edge; disable bit not taken.
        do_reset();
        repeat (5) @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'b1000_0000;
        @(negedge clk); wr_en = 1'b0;
        check(!wdg_rst_n, "R5 bad check gives immediate reset", int'(wdg_rst_n), 0);
        repeat (LEN + 2) @(negedge clk);
        wr(1'b1, 8'h55); wr(1'b1, 8'hAA);
        wait_low(1'b0, 1300, w, wd);
        check(w < 1300 && wd == LEN, "R5 control unchanged after bad write", w, 1020);

        // Disable with good check: no expiry.
        wr(1'b0, 8'b1101_0000);
        quiet(3000, lows);
        check(lows == 0, "R6 disabled watchdog never expires", lows, 0);
        wr(1'b0, 8'b0101_0000);

        // Interrupt route.
        irq_en = 1'b1;
        wait_low(1'b1, 1300, w, wd);
        check(w < 1300 && wd == LEN, "R7 R8 interrupt pulse", wd, LEN);
        check(wdg_rst_n, "R7 reset stays high on interrupt route", int'(wdg_rst_n), 1);
        irq_en = 1'b0;

        // Prescale 2 (/2): expiry near 510 * PRE cycles after service.
        wr(1'b0, 8'b0101_0010);
        wr(1'b1, 8'h55); wr(1'b1, 8'hAA);
        wait_low(1'b0, 4000, w, wd);
        check(w > 510 * PRE - 16 && w < 512 * PRE + 16, "R2 expiry time /2", w, 510 * PRE);

        // Prescale 3 (/4).
        wr(1'b0, 8'b0101_0011);
        wr(1'b1, 8'h55); wr(1'b1, 8'hAA);
        wait_low(1'b0, 6000, w, wd);
        check(w > 1020 * PRE - 32 && w < 1024 * PRE + 32, "R2 expiry time /4", w, 1020 * PRE);

        // Bad check during an active pulse does not extend it.
        wr(1'b0, 8'b0101_0000);
        wr(1'b0, 8'h00);
        repeat (4) @(negedge clk);
        wr(1'b0, 8'h00);
        wait_low(1'b0, 10, w, wd);
        check(wd < LEN, "R8 no retrigger during pulse", wd, LEN - 6);

        repeat (20) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule